// File: doc/BRIEF.md
# Memory Controller Bank Configuration Unit

This block is the software-visible configuration front end of a four-bank memory controller. Software reaches every internal register through two bus locations: a pointer location that selects an internal register offset, and a data location that reads or writes the selected register. The block keeps the error status and error address, the main configuration word, the refresh and power-management values, the ECC settings and four bank configuration words. Each register applies its own write mask. Two status bits record transitions of the configuration word.

From the four bank words the block decodes a base address and a size for each bank. It compares a probe address against every live bank and drives a one-hot hit vector and a miss flag. A bank is live only while its own enable and the global enable in the configuration word are both set. An ECC error status register drives a level interrupt toward the core.

Register writes take effect at the clock edge on which the bus write is presented. Read data and the hit decode are combinational from the current state.

Top module: `mcb_cfg_unit`

## Requirements
- R1: After reset the pointer reads 0, the configuration register reads 0x00800000, refresh reads 0x05F00000, power management reads 0x07C00000, and status, error and ECC registers read 0. The interrupt is low, no bank hits and the miss flag is high.
- R2: A write to bus location 0x10 loads the pointer and a read of 0x10 returns it. Reads and writes at location 0x11 reach the register whose offset the pointer holds. Any other bus location reads 0 and a write there changes nothing.
- R3: The timing register (offset 0x80) and any offset not in the register set read 0xFFFFFFFF. Writes there have no visible effect.
- R4: The two error status registers (offsets 0x00, 0x08) clear the bits written as 1. The status register (offset 0x24) ignores writes.
- R5: A write to the configuration register (offset 0x20) keeps bits 31:21 only. When bit 31 goes 0→1, status bit 31 clears; when it goes 1→0, status bit 31 sets. Status bit 30 sets when configuration bit 30 goes 0→1 and clears when it goes 1→0.
- R6: The refresh register (0x30) stores data AND 0x3FF80000. Power management (0x34) stores (data AND 0xF8000000) OR 0x07C00000. ECC configuration (0x94) stores data AND 0x00F00000. The error address register (0x10) stores all 32 bits.
- R7: Bank configuration registers at offsets 0x40, 0x44, 0x48 and 0x4C (banks 0 to 3) store data AND 0xFFDEE001. In each, bit 0 is the enable, bits 31:23 are the base and bits 19:17 are the size code.
- R8: A bank hits when its enable bit and configuration bit 31 are both set, its size code is not 7, and the probe address matches the base above the bank size. The bank size is 4 MB shifted left by the code, and base bit 22 counts as 0.
- R9: The hit vector (bit n for bank n) is one-hot or zero, and the lowest-numbered matching bank wins. The miss flag is high exactly when no bank matches.
- R10: The ECC error status register (0x98) stores data AND 0xFFF0F000. The interrupt rises when this register changes from zero to nonzero, stays high across nonzero-to-nonzero writes, and falls when a write makes it zero.
- R11: The hit vector follows the probe address without a clock edge. A bank register write changes the hit vector only after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busLoc | input | 10 | Bus location: 0x10 pointer, 0x11 data |
| busWr | input | 1 | Write strobe for the current location |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current location |
| probeAddr | input | 32 | Address tested against the bank windows |
| bankHit | output | 4 | One-hot bank hit, bit n for bank n |
| bankMiss | output | 1 | No bank window contains the probe address |
| eccIrq | output | 1 | ECC error interrupt, active high |

## Verification
A wrong pointer or a wrong select decode shows at the next data-location read as another register's value or as all ones. A wrong write mask or a missed status transition shows on the first readback after the offending write. A bank word stored wrongly, or a gate on the global enable that is lost, shows on the hit vector in the cycle after the write, without any register read. Probe addresses at the first and last byte of each window, and just past it, make a size or base error visible at once. The interrupt flop is checked on each ECC status write and therefore cannot drift from the register unseen.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int BASE_W     = 9;
  localparam int CODE_W     = 3;

  // Internal register offsets
  localparam logic [DATA_W-1:0] OFS_ERR0   = 32'h0000_0000;
  localparam logic [DATA_W-1:0] OFS_ERR1   = 32'h0000_0008;
  localparam logic [DATA_W-1:0] OFS_EADDR  = 32'h0000_0010;
  localparam logic [DATA_W-1:0] OFS_CFG    = 32'h0000_0020;
  localparam logic [DATA_W-1:0] OFS_STAT   = 32'h0000_0024;
  localparam logic [DATA_W-1:0] OFS_RFSH   = 32'h0000_0030;
  localparam logic [DATA_W-1:0] OFS_PWR    = 32'h0000_0034;
  localparam logic [DATA_W-1:0] OFS_BANK   = 32'h0000_0040;
  localparam logic [DATA_W-1:0] OFS_TMG    = 32'h0000_0080;
  localparam logic [DATA_W-1:0] OFS_ECCCFG = 32'h0000_0094;
  localparam logic [DATA_W-1:0] OFS_ECCST  = 32'h0000_0098;

  // Write masks and reset values
  localparam logic [DATA_W-1:0] MASK_CFG    = 32'hFFE0_0000;
  localparam logic [DATA_W-1:0] MASK_RFSH   = 32'h3FF8_0000;
  localparam logic [DATA_W-1:0] MASK_PWR    = 32'hF800_0000;
  localparam logic [DATA_W-1:0] FORCE_PWR   = 32'h07C0_0000;
  localparam logic [DATA_W-1:0] MASK_BANK   = 32'hFFDE_E001;
  localparam logic [DATA_W-1:0] MASK_ECCCFG = 32'h00F0_0000;
  localparam logic [DATA_W-1:0] MASK_ECCST  = 32'hFFF0_F000;
  localparam logic [DATA_W-1:0] RST_CFG     = 32'h0080_0000;
  localparam logic [DATA_W-1:0] RST_RFSH    = 32'h05F0_0000;
  localparam logic [DATA_W-1:0] RST_PWR     = 32'h07C0_0000;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ERR0, SEL_ERR1, SEL_EADDR, SEL_CFG, SEL_STAT,
    SEL_RFSH, SEL_PWR, SEL_BANK, SEL_TMG, SEL_ECCCFG, SEL_ECCST
  } regSel_e;

  typedef struct packed {
    logic                  wr;
    regSel_e               sel;
    logic [BANK_IDX_W-1:0] bank;
  } ctlStrobe_t;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic              en;
  } bankField_t;
endpackage

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
  import mcb_pkg::*;
#(
  parameter int                LOC_W    = 10,
  parameter logic [LOC_W-1:0]  PTR_LOC  = 10'h010,
  parameter logic [LOC_W-1:0]  DATA_LOC = 10'h011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LOC_W-1:0]  busLoc,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] dataRd,
  output logic [DATA_W-1:0] busRdata,
  output ctlStrobe_t        strb
);
  logic [DATA_W-1:0] ptrReg;
  logic isPtr, isData;

  assign isPtr  = (busLoc == PTR_LOC);
  assign isData = (busLoc == DATA_LOC);

  always_ff @(posedge clk) begin
    if (!rstN) ptrReg <= '0;
    else if (busWr && isPtr) ptrReg <= busWdata;
  end

  // Offset decode from the pointer
  always_comb begin
    strb.wr   = busWr && isData;
    strb.sel  = SEL_NONE;
    strb.bank = '0;
    case (ptrReg)
      OFS_ERR0:   strb.sel = SEL_ERR0;
      OFS_ERR1:   strb.sel = SEL_ERR1;
      OFS_EADDR:  strb.sel = SEL_EADDR;
      OFS_CFG:    strb.sel = SEL_CFG;
      OFS_STAT:   strb.sel = SEL_STAT;
      OFS_RFSH:   strb.sel = SEL_RFSH;
      OFS_PWR:    strb.sel = SEL_PWR;
      OFS_TMG:    strb.sel = SEL_TMG;
      OFS_ECCCFG: strb.sel = SEL_ECCCFG;
      OFS_ECCST:  strb.sel = SEL_ECCST;
      default:    strb.sel = SEL_NONE;
    endcase
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (ptrReg == OFS_BANK + DATA_W'(4 * i)) begin
        strb.sel  = SEL_BANK;
        strb.bank = BANK_IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (isPtr)       busRdata = ptrReg;
    else if (isData) busRdata = dataRd;
    else             busRdata = '0;
  end

  // R2: pointer moves only on a write to its own location
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && isPtr) |=> $stable(ptrReg));
endmodule

// File: rtl/mcb_regs.sv
module mcb_regs
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dataRd,
  output bankField_t        bankCfg [NUM_BANKS],
  output logic              cfgEnable,
  output logic              eccIrq
);
  logic [DATA_W-1:0] err0, err1, eaddr, cfgReg, rfsh, pwr, eccCfg, eccSt;
  logic [DATA_W-1:0] bankReg [NUM_BANKS];
  logic [1:0]        statHi;
  logic              irqReg;
  logic [DATA_W-1:0] cfgNext, eccNext;

  assign cfgNext = wdata & MASK_CFG;
  assign eccNext = wdata & MASK_ECCST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      err0   <= '0;
      err1   <= '0;
      eaddr  <= '0;
      cfgReg <= RST_CFG;
      rfsh   <= RST_RFSH;
      pwr    <= RST_PWR;
      eccCfg <= '0;
      eccSt  <= '0;
      statHi <= '0;
      irqReg <= 1'b0;
      for (int i = 0; i < NUM_BANKS; i++) bankReg[i] <= '0;
    end else if (strb.wr) begin
      case (strb.sel)
        SEL_ERR0:   err0  <= err0 & ~wdata;
        SEL_ERR1:   err1  <= err1 & ~wdata;
        SEL_EADDR:  eaddr <= wdata;
        SEL_CFG: begin
          cfgReg <= cfgNext;
          if (!cfgReg[31] && cfgNext[31])      statHi[1] <= 1'b0;
          else if (cfgReg[31] && !cfgNext[31]) statHi[1] <= 1'b1;
          if (!cfgReg[30] && cfgNext[30])      statHi[0] <= 1'b1;
          else if (cfgReg[30] && !cfgNext[30]) statHi[0] <= 1'b0;
        end
        SEL_RFSH:   rfsh   <= wdata & MASK_RFSH;
        SEL_PWR:    pwr    <= (wdata & MASK_PWR) | FORCE_PWR;
        SEL_BANK:   bankReg[strb.bank] <= wdata & MASK_BANK;
        SEL_ECCCFG: eccCfg <= wdata & MASK_ECCCFG;
        SEL_ECCST: begin
          eccSt <= eccNext;
          if (eccSt == '0 && eccNext != '0)      irqReg <= 1'b1;
          else if (eccSt != '0 && eccNext == '0) irqReg <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_ERR0:   dataRd = err0;
      SEL_ERR1:   dataRd = err1;
      SEL_EADDR:  dataRd = eaddr;
      SEL_CFG:    dataRd = cfgReg;
      SEL_STAT:   dataRd = {statHi, {(DATA_W-2){1'b0}}};
      SEL_RFSH:   dataRd = rfsh;
      SEL_PWR:    dataRd = pwr;
      SEL_BANK:   dataRd = bankReg[strb.bank];
      SEL_ECCCFG: dataRd = eccCfg;
      SEL_ECCST:  dataRd = eccSt;
      default:    dataRd = '1;
    endcase
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gFields
    assign bankCfg[g].base = bankReg[g][31:23];
    assign bankCfg[g].code = bankReg[g][19:17];
    assign bankCfg[g].en   = bankReg[g][0];
  end

  assign cfgEnable = cfgReg[31];
  assign eccIrq    = irqReg;

  // R5: status bit 31 mirrors enable transitions
  a_r5_stat_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgReg[31]) |-> !statHi[1]);
  a_r5_stat_set: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgReg[31]) |-> statHi[1]);
  // R4: status is read-only
  a_r4_stat_ro: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.sel == SEL_STAT) |=> $stable(statHi));
  // R10: interrupt rises only from an ECC status write and tracks a nonzero register
  a_r10_irq_src: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReg) |-> $past(strb.wr && strb.sel == SEL_ECCST));
  a_r10_irq_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    irqReg |-> eccSt != '0);
endmodule

// File: rtl/mcb_bank_decode.sv
module mcb_bank_decode
  import mcb_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int MIN_SIZE_LOG2 = 22
) (
  input  logic [ADDR_W-1:0]   probeAddr,
  input  bankField_t          bankCfg [NUM_BANKS],
  input  logic                globalEn,
  output logic [NUM_BANKS-1:0] bankHit,
  output logic                bankMiss
);
  localparam int BASE_LSB = ADDR_W - BASE_W;
  localparam logic [CODE_W-1:0] BAD_CODE = '1;

  logic [NUM_BANKS-1:0] rawHit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic [ADDR_W-1:0] sizeMask, baseFull;
    assign sizeMask = ~((ADDR_W'(1) << (MIN_SIZE_LOG2 + int'(bankCfg[g].code))) - ADDR_W'(1));
    assign baseFull = {bankCfg[g].base, {BASE_LSB{1'b0}}};
    assign rawHit[g] = globalEn && bankCfg[g].en && (bankCfg[g].code != BAD_CODE)
                       && (((probeAddr ^ baseFull) & sizeMask) == '0);
  end

  // Lowest-numbered bank wins
  always_comb begin
    bankHit = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (rawHit[i]) begin
        bankHit    = '0;
        bankHit[i] = 1'b1;
      end
    end
  end

  assign bankMiss = ~|rawHit;
endmodule

// File: rtl/mcb_cfg_unit.sv
module mcb_cfg_unit
  import mcb_pkg::*;
#(
  parameter int               LOC_W         = 10,
  parameter logic [LOC_W-1:0] PTR_LOC       = 10'h010,
  parameter logic [LOC_W-1:0] DATA_LOC      = 10'h011,
  parameter int               ADDR_W        = 32,
  parameter int               MIN_SIZE_LOG2 = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LOC_W-1:0]     busLoc,
  input  logic                 busWr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [ADDR_W-1:0]    probeAddr,
  output logic [NUM_BANKS-1:0] bankHit,
  output logic                 bankMiss,
  output logic                 eccIrq
);
  ctlStrobe_t        strb;
  logic [DATA_W-1:0] dataRd;
  bankField_t        bankCfg [NUM_BANKS];
  logic              cfgEnable;

  mcb_ctrl #(.LOC_W(LOC_W), .PTR_LOC(PTR_LOC), .DATA_LOC(DATA_LOC)) uCtrl (
    .clk(clk), .rstN(rstN), .busLoc(busLoc), .busWr(busWr),
    .busWdata(busWdata), .dataRd(dataRd), .busRdata(busRdata), .strb(strb)
  );

  mcb_regs uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .dataRd(dataRd), .bankCfg(bankCfg), .cfgEnable(cfgEnable), .eccIrq(eccIrq)
  );

  mcb_bank_decode #(.ADDR_W(ADDR_W), .MIN_SIZE_LOG2(MIN_SIZE_LOG2)) uDec (
    .probeAddr(probeAddr), .bankCfg(bankCfg), .globalEn(cfgEnable),
    .bankHit(bankHit), .bankMiss(bankMiss)
  );

  // R8: no window is live while the global enable is clear
  a_r8_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> bankHit == '0);
  // R9: at most one hit, and miss excludes any hit
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankHit));
  a_r9_miss_excl: assert property (@(posedge clk) disable iff (!rstN)
    bankMiss |-> bankHit == '0);
endmodule

// File: tb/tb_mcb_cfg_unit.sv
module tb_mcb_cfg_unit;
  localparam logic [9:0] PTR  = 10'h010;
  localparam logic [9:0] DATA = 10'h011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busLoc = PTR;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] probeAddr = '0;
  logic [3:0]  bankHit;
  logic        bankMiss;
  logic        eccIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mcb_cfg_unit dut (
    .clk(clk), .rstN(rstN), .busLoc(busLoc), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .probeAddr(probeAddr),
    .bankHit(bankHit), .bankMiss(bankMiss), .eccIrq(eccIrq)
  );

  typedef struct packed {
    logic [31:0] ofs;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TBL [NVEC] = '{
    '{32'h30, 32'hFFFF_FFFF, 32'h3FF8_0000, 8'd6},  // R6 refresh
    '{32'h34, 32'hFFFF_FFFF, 32'hFFC0_0000, 8'd6},  // R6 power
    '{32'h34, 32'h0000_0000, 32'h07C0_0000, 8'd6},  // R6 power forced bits
    '{32'h94, 32'hFFFF_FFFF, 32'h00F0_0000, 8'd6},  // R6 ECC config
    '{32'h10, 32'h1234_5678, 32'h1234_5678, 8'd6},  // R6 error address
    '{32'h00, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4},  // R4 W1C
    '{32'h08, 32'h0000_0001, 32'h0000_0000, 8'd4},  // R4 W1C
    '{32'h24, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4},  // R4 read-only
    '{32'h80, 32'h0000_0000, 32'hFFFF_FFFF, 8'd3},  // R3 timing
    '{32'h5C, 32'h0000_0000, 32'hFFFF_FFFF, 8'd3},  // R3 unknown
    '{32'h4C, 32'hFFFF_FFFF, 32'hFFDE_E001, 8'd7},  // R7 mask
    '{32'h4C, 32'h0000_0000, 32'h0000_0000, 8'd7}   // R7 clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wrBus(input logic [9:0] loc, input logic [31:0] d);
    @(negedge clk);
    busLoc = loc; busWr = 1'b1; busWdata = d;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic wrReg(input logic [31:0] ofs, input logic [31:0] d);
    wrBus(PTR, ofs);
    wrBus(DATA, d);
  endtask

  task automatic rdReg(input logic [31:0] ofs, output logic [31:0] d);
    wrBus(PTR, ofs);
    @(negedge clk);
    busLoc = DATA;
    #1 d = busRdata;
  endtask

  task automatic probe(input logic [31:0] a, input logic [3:0] expHit, input string req);
    @(negedge clk);
    probeAddr = a;
    #1;
    check(req, {27'b0, bankMiss, bankHit}, {27'b0, (expHit == 4'b0), expHit});
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk); busLoc = PTR; #1 check("R1 ptr", busRdata, 32'h0);
    check("R1 irq/hit/miss", {27'b0, eccIrq, bankMiss, bankHit}, 32'h10);
    rdReg(32'h20, rd); check("R1 cfg", rd, 32'h0080_0000);
    rdReg(32'h30, rd); check("R1 refresh", rd, 32'h05F0_0000);
    rdReg(32'h34, rd); check("R1 power", rd, 32'h07C0_0000);
    rdReg(32'h24, rd); check("R1 status", rd, 32'h0);
    rdReg(32'h98, rd); check("R1 eccst", rd, 32'h0);

    // Table walk: write through data location, read back
    for (int i = 0; i < NVEC; i++) begin
      wrReg(TBL[i].ofs, TBL[i].wd);
      rdReg(TBL[i].ofs, rd);
      check($sformatf("R%0d ofs=%02h", TBL[i].req, TBL[i].ofs[7:0]), rd, TBL[i].ex);
    end

    // R2 pointer readback and foreign locations
    wrBus(PTR, 32'h0000_0034);
    @(negedge clk); busLoc = PTR; #1 check("R2 ptr read", busRdata, 32'h34);
    wrBus(10'h005, 32'h0000_0020);
    @(negedge clk); busLoc = 10'h005; #1 check("R2 foreign read", busRdata, 32'h0);
    busLoc = PTR; #1 check("R2 foreign write", busRdata, 32'h34);

    // R5 configuration mask and status transitions
    wrReg(32'h20, 32'hFFFF_FFFF);
    rdReg(32'h20, rd); check("R5 cfg mask", rd, 32'hFFE0_0000);
    rdReg(32'h24, rd); check("R5 stat rise", rd, 32'h4000_0000);
    wrReg(32'h20, 32'h0000_0000);
    rdReg(32'h24, rd); check("R5 stat fall", rd, 32'h8000_0000);
    wrReg(32'h20, 32'h8000_0000);
    rdReg(32'h24, rd); check("R5 stat reenable", rd, 32'h0);

    // R8 bank 0: base 0x08000000, 8 MB
    wrReg(32'h40, 32'h0802_0001);
    probe(32'h0800_0000, 4'b0001, "R8 first");
    probe(32'h087F_FFFC, 4'b0001, "R8 last");
    probe(32'h0880_0000, 4'b0000, "R8 past");
    wrReg(32'h20, 32'h0000_0000);
    probe(32'h0800_0000, 4'b0000, "R8 global off");
    wrReg(32'h20, 32'h8000_0000);
    // R8 size code 7 never hits
    wrReg(32'h44, 32'h100E_0001);
    probe(32'h1000_0000, 4'b0000, "R8 code7");
    // R8 bank 3: 4 MB at 0x20000000, base bit 22 treated as 0
    wrReg(32'h4C, 32'h2000_0001);
    probe(32'h203F_FFFF, 4'b1000, "R8 4MB last");
    probe(32'h2040_0000, 4'b0000, "R8 4MB past");
    // R9 overlap: bank 2 covers 256 MB at 0
    wrReg(32'h48, 32'h000C_0001);
    probe(32'h0800_0000, 4'b0001, "R9 lowest wins");
    probe(32'h0000_0000, 4'b0100, "R9 bank2");
    probe(32'hF000_0000, 4'b0000, "R9 miss");

    // R11 write becomes visible only after its edge
    wrBus(PTR, 32'h44);
    probe(32'h3000_0000, 4'b0000, "R11 before");
    @(negedge clk);
    busLoc = DATA; busWr = 1'b1; busWdata = 32'h3000_0001;
    #1 check("R11 pre-edge", {28'b0, bankHit}, 32'h0);
    @(posedge clk); #1 busWr = 1'b0;
    check("R11 post-edge", {28'b0, bankHit}, 32'h2);

    // R10 ECC status and interrupt
    wrReg(32'h98, 32'hFFFF_FFFF);
    check("R10 irq rise", {31'b0, eccIrq}, 32'h1);
    rdReg(32'h98, rd); check("R10 mask", rd, 32'hFFF0_F000);
    wrReg(32'h98, 32'h0000_0F00);
    check("R10 irq fall", {31'b0, eccIrq}, 32'h0);
    wrReg(32'h98, 32'h0000_1000);
    check("R10 irq rise2", {31'b0, eccIrq}, 32'h1);
    wrReg(32'h98, 32'h0000_2000);
    check("R10 irq hold", {31'b0, eccIrq}, 32'h1);
    wrReg(32'h98, 32'h0);
    check("R10 irq clear", {31'b0, eccIrq}, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule